// File: doc/BRIEF.md
# Mode-Selectable Up/Down Timer Counter

This block is a count register paired with a compare register. A small control byte and a two-bit mode field decide how the count moves. It has three modes. In general-purpose mode the count only rises, and it may optionally fall back to zero when it reaches the compare value. Up/down mode A follows a direction input and can refill the count from the compare register when the count runs below zero. Up/down mode B follows the same direction input but never refills.

Software reaches the block through a word-wide register write port, a combinational read port and a single-bit write path to the control byte. While the counter runs, the write rules keep its configuration fixed and let only the run bit change. A clock-enable input gates every count step. Two one-cycle flags report an equality with the compare value and an underflow.

Top module: `updn_timer`

## Requirements
- R1: After reset the control byte, the mode field, the compare value and the count all read 0, and both flags are low.
- R2: The control byte sits at address 0. Bit 6 is run, bit 3 is reload-enable and bit 2 is clear-enable. Bits 7, 5, 4, 1 and 0 always read 0. The mode field sits at address 1 (bit 0 selects the up/down modes, bit 1 selects mode B). The compare value sits at address 2, and the count reads at address 3.
- R3: The count steps only on a clock where run is 1 and `clk_en` is 1. On any other clock it holds.
- R4: In general-purpose mode each step adds one, whatever `dir_up` is. With clear-enable at 0, the count runs free and wraps from 0xFFFF to 0x0000.
- R5: In general-purpose mode with clear-enable at 1, a step taken while the count equals the compare value loads 0.
- R6: In either up/down mode a step adds one when `dir_up` is 1 and subtracts one when it is 0.
- R7: A down step from 0x0000 in an up/down mode is an underflow. The count becomes 0xFFFF unless R8 applies, and `uf_o` is high in the following cycle.
- R8: In up/down mode A with reload-enable at 1, an underflow loads the compare value into the count.
- R9: Reload-enable has no effect in general-purpose mode or in mode B. Clear-enable has no effect in either up/down mode.
- R10: While run is 1, a byte write to the control byte changes only bit 6.
- R11: A single-bit write (`bit_we`, `bit_sel`, `bit_val`) sets one control bit under the same rule as R10. Unimplemented bits stay 0. A byte write to the control byte in the same cycle takes priority.
- R12: Writes to the mode field are ignored while run is 1. The compare value can be written at any time.
- R13: In every mode, `match_o` is high in the cycle after a step taken while the count equals the compare value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 16 | Register write data |
| bit_we | input | 1 | Single-bit control write strobe |
| bit_sel | input | 3 | Control bit index for a single-bit write |
| bit_val | input | 1 | Value for the single-bit write |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 16 | Read data (combinational) |
| clk_en | input | 1 | Count step enable |
| dir_up | input | 1 | Direction in up/down modes (1 = up) |
| match_o | output | 1 | Equality flag, one cycle per matching step |
| uf_o | output | 1 | Underflow flag |

## Verification
The equality event and the underflow event can occur on the same step. The bench provokes this in mode A with reload enabled and a compare value of zero, stepping down from a count of zero. That step must raise `match_o` and `uf_o` together, and the reload leaves the count at zero, so the overlap repeats on every following down step. The bench checks that both flags and the count agree with its own step model on each of those cycles. It also checks that a match in mode B never clears the count.

// File: rtl/updn_timer_pkg.sv
package updn_timer_pkg;

  // control byte layout
  localparam int CTRL_W     = 8;
  localparam int RUN_BIT    = 6;
  localparam int RELOAD_BIT = 3;
  localparam int CLEAR_BIT  = 2;
  localparam logic [CTRL_W-1:0] RUN_MASK  = CTRL_W'(1) << RUN_BIT;
  localparam logic [CTRL_W-1:0] IMPL_MASK = (CTRL_W'(1) << RUN_BIT)
                                          | (CTRL_W'(1) << RELOAD_BIT)
                                          | (CTRL_W'(1) << CLEAR_BIT);

  // register addresses
  localparam int ADDR_CTRL = 0;
  localparam int ADDR_MODE = 1;
  localparam int ADDR_CMP  = 2;
  localparam int ADDR_CNT  = 3;

  typedef enum logic [1:0] {
    MODE_GP  = 2'd0,
    MODE_UDA = 2'd1,
    MODE_UDB = 2'd2
  } tmode_e;

  function automatic tmode_e decode_mode(input logic sel_ud, input logic sel_b);
    if (!sel_ud)     return MODE_GP;
    else if (!sel_b) return MODE_UDA;
    else             return MODE_UDB;
  endfunction

  // apply write protection: while running only the run bit may move
  function automatic logic [CTRL_W-1:0] guard_ctrl(input logic [CTRL_W-1:0] old_v,
                                                   input logic [CTRL_W-1:0] cand,
                                                   input logic running);
    logic [CTRL_W-1:0] c;
    c = cand & IMPL_MASK;
    if (running) return (old_v & ~RUN_MASK) | (c & RUN_MASK);
    return c;
  endfunction

  function automatic logic [CTRL_W-1:0] with_bit(input logic [CTRL_W-1:0] old_v,
                                                 input logic [2:0] idx,
                                                 input logic val);
    logic [CTRL_W-1:0] r;
    r = old_v;
    r[idx] = val;
    return r;
  endfunction

endpackage

// File: rtl/updn_timer_regs.sv
module updn_timer_regs
  import updn_timer_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic              bit_we,
  input  logic [2:0]        bit_sel,
  input  logic              bit_val,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic              sel_ud_q,
  output logic              sel_b_q,
  output logic [CNT_W-1:0]  cmp_q
);

  logic              running;
  logic              wr_ctrl, wr_mode, wr_cmp;
  logic [CTRL_W-1:0] ctrl_cand;
  logic [CTRL_W-1:0] ctrl_nxt;
  logic              ctrl_upd;

  assign running = ctrl_q[RUN_BIT];
  assign wr_ctrl = wr_en && (wr_addr == ADDR_W'(ADDR_CTRL));
  assign wr_mode = wr_en && (wr_addr == ADDR_W'(ADDR_MODE));
  assign wr_cmp  = wr_en && (wr_addr == ADDR_W'(ADDR_CMP));

  // byte write wins over a bit write in the same cycle
  always_comb begin
    ctrl_cand = ctrl_q;
    ctrl_upd  = 1'b0;
    if (wr_ctrl) begin
      ctrl_cand = wr_data[CTRL_W-1:0];
      ctrl_upd  = 1'b1;
    end else if (bit_we) begin
      ctrl_cand = with_bit(ctrl_q, bit_sel, bit_val);
      ctrl_upd  = 1'b1;
    end
    ctrl_nxt = guard_ctrl(ctrl_q, ctrl_cand, running);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (ctrl_upd) begin
      ctrl_q <= ctrl_nxt;
    end
  end

  // mode field frozen while running
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_ud_q <= 1'b0;
      sel_b_q  <= 1'b0;
    end else if (wr_mode && !running) begin
      sel_ud_q <= wr_data[0];
      sel_b_q  <= wr_data[1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q <= '0;
    end else if (wr_cmp) begin
      cmp_q <= wr_data;
    end
  end

endmodule

// File: rtl/updn_timer_core.sv
module updn_timer_core
  import updn_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             clk_en,
  input  logic             dir_up,
  input  tmode_e           mode,
  input  logic             reload_en,
  input  logic             clear_en,
  input  logic [CNT_W-1:0] cmp,
  output logic [CNT_W-1:0] count,
  output logic             match_o,
  output logic             uf_o,
  output logic             tick,
  output logic             hit,
  output logic             under,
  output logic             reload_fire,
  output logic             clear_fire
);

  localparam logic [CNT_W-1:0] CNT_ZERO = '0;
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0] CNT_TOP  = '1;

  // arithmetic of one count step, given that a step happens
  function automatic logic [CNT_W-1:0] step_count(input tmode_e m,
                                                  input logic [CNT_W-1:0] c,
                                                  input logic [CNT_W-1:0] cv,
                                                  input logic up,
                                                  input logic rl,
                                                  input logic cl);
    if (m == MODE_GP) begin
      if (cl && (c == cv)) return CNT_ZERO;
      return c + CNT_ONE;
    end
    if (up) return c + CNT_ONE;
    if (c == CNT_ZERO) begin
      if ((m == MODE_UDA) && rl) return cv;
      return CNT_TOP;
    end
    return c - CNT_ONE;
  endfunction

  logic [CNT_W-1:0] count_nxt;

  assign tick        = run && clk_en;
  assign hit         = tick && (count == cmp);
  assign under       = tick && (mode != MODE_GP) && !dir_up && (count == CNT_ZERO);
  assign reload_fire = under && (mode == MODE_UDA) && reload_en;
  assign clear_fire  = hit && (mode == MODE_GP) && clear_en;

  assign count_nxt = step_count(mode, count, cmp, dir_up, reload_en, clear_en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
    end else if (tick) begin
      count <= count_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match_o <= 1'b0;
      uf_o    <= 1'b0;
    end else begin
      match_o <= hit;
      uf_o    <= under;
    end
  end

endmodule

// File: rtl/updn_timer.sv
module updn_timer
  import updn_timer_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic              bit_we,
  input  logic [2:0]        bit_sel,
  input  logic              bit_val,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [CNT_W-1:0]  rd_data,
  input  logic              clk_en,
  input  logic              dir_up,
  output logic              match_o,
  output logic              uf_o
);

  logic [CTRL_W-1:0] ctrl_w;
  logic              sel_ud_w, sel_b_w;
  logic [CNT_W-1:0]  cmp_w;
  logic [CNT_W-1:0]  count_w;
  tmode_e            mode_w;
  logic              run_w, reload_en_w, clear_en_w;

  // named internal events for the checker
  logic tick_w, hit_w, under_w, reload_w, clear_w;

  updn_timer_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .bit_we   (bit_we),
    .bit_sel  (bit_sel),
    .bit_val  (bit_val),
    .ctrl_q   (ctrl_w),
    .sel_ud_q (sel_ud_w),
    .sel_b_q  (sel_b_w),
    .cmp_q    (cmp_w)
  );

  assign mode_w      = decode_mode(sel_ud_w, sel_b_w);
  assign run_w       = ctrl_w[RUN_BIT];
  assign reload_en_w = ctrl_w[RELOAD_BIT];
  assign clear_en_w  = ctrl_w[CLEAR_BIT];

  updn_timer_core #(.CNT_W(CNT_W)) u_core (
    .clk         (clk),
    .rst_n       (rst_n),
    .run         (run_w),
    .clk_en      (clk_en),
    .dir_up      (dir_up),
    .mode        (mode_w),
    .reload_en   (reload_en_w),
    .clear_en    (clear_en_w),
    .cmp         (cmp_w),
    .count       (count_w),
    .match_o     (match_o),
    .uf_o        (uf_o),
    .tick        (tick_w),
    .hit         (hit_w),
    .under       (under_w),
    .reload_fire (reload_w),
    .clear_fire  (clear_w)
  );

  always_comb begin
    case (rd_addr)
      ADDR_W'(ADDR_CTRL): rd_data = CNT_W'(ctrl_w);
      ADDR_W'(ADDR_MODE): rd_data = CNT_W'({sel_b_w, sel_ud_w});
      ADDR_W'(ADDR_CMP):  rd_data = cmp_w;
      default:            rd_data = count_w;
    endcase
  end

endmodule

// File: rtl/updn_timer_chk.sv
module updn_timer_chk
  import updn_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic              wr_ctrl,
  input logic              dir_up,
  input logic [CTRL_W-1:0] ctrl,
  input logic [1:0]        mode_bits,
  input logic [CNT_W-1:0]  count,
  input logic [CNT_W-1:0]  cmp,
  input logic              uf_o,
  input logic              match_o
);

  logic run, rl, cl, gp, uda;
  assign run = ctrl[RUN_BIT];
  assign rl  = ctrl[RELOAD_BIT];
  assign cl  = ctrl[CLEAR_BIT];
  assign gp  = !mode_bits[0];
  assign uda = mode_bits[0] && !mode_bits[1];

  // R3
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(count));

  // R2
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl & ~IMPL_MASK) == '0);

  // R5
  gp_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && gp && cl && count == cmp) |=> count == '0);

  // R4
  gp_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && gp && !(cl && count == cmp)) |=> count == ($past(count) + CNT_W'(1)));

  // R8
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && uda && rl && !dir_up && count == '0) |=> count == $past(cmp));

  // R7
  underflow_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !gp && !dir_up && count == '0) |=> uf_o);

  // R13
  match_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && count == cmp) |=> match_o);

  // R10
  protect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && wr_ctrl) |=> ((ctrl & ~RUN_MASK) == ($past(ctrl) & ~RUN_MASK)));

  // R12
  mode_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> $stable(mode_bits));

endmodule

bind updn_timer updn_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick      (tick_w),
  .wr_ctrl   (wr_en && (wr_addr == '0)),
  .dir_up    (dir_up),
  .ctrl      (ctrl_w),
  .mode_bits ({sel_b_w, sel_ud_w}),
  .count     (count_w),
  .cmp       (cmp_w),
  .uf_o      (uf_o),
  .match_o   (match_o)
);

// File: tb/updn_timer_tb.sv
`timescale 1ns/1ps
module updn_timer_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        bit_we = 1'b0;
  logic [2:0]  bit_sel = '0;
  logic        bit_val = 1'b0;
  logic [1:0]  rd_addr = 2'd3;
  logic [15:0] rd_data;
  logic        clk_en = 1'b0;
  logic        dir_up = 1'b0;
  logic        match_o, uf_o;

  int tests = 0;
  int fails = 0;

  // bench-side model state
  logic        m_run = 0, m_rl = 0, m_clr = 0, m_ud = 0, m_b = 0;
  logic [15:0] m_cmp = 0, m_cnt = 0;
  logic        m_match = 0, m_uf = 0;

  always #5 clk = ~clk;

  updn_timer u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .bit_we(bit_we), .bit_sel(bit_sel), .bit_val(bit_val), .rd_addr(rd_addr),
    .rd_data(rd_data), .clk_en(clk_en), .dir_up(dir_up), .match_o(match_o), .uf_o(uf_o)
  );

  task automatic chk(input string req, input string what, input logic [15:0] act,
                     input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic rdreg(input logic [1:0] a, output logic [15:0] v);
    rd_addr = a;
    #1;
    v = rd_data;
    rd_addr = 2'd3;
    #1;
  endtask

  function automatic logic [7:0] m_ctrl();
    return {1'b0, m_run, 2'b00, m_rl, m_clr, 2'b00};
  endfunction

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    clk_en = 0; wr_en = 1; wr_addr = a; wr_data = d;
    @(posedge clk); @(negedge clk);
    wr_en = 0;
    if (a == 2'd0) begin
      if (!m_run) begin m_rl = d[3]; m_clr = d[2]; end
      m_run = d[6];
    end else if (a == 2'd1) begin
      if (!m_run) begin m_ud = d[0]; m_b = d[1]; end
    end else if (a == 2'd2) m_cmp = d;
    m_match = 0; m_uf = 0;
  endtask

  task automatic bitw(input logic [2:0] s, input logic v);
    clk_en = 0; bit_we = 1; bit_sel = s; bit_val = v;
    @(posedge clk); @(negedge clk);
    bit_we = 0;
    if (s == 3'd6) m_run = v;
    else if (!m_run && s == 3'd3) m_rl = v;
    else if (!m_run && s == 3'd2) m_clr = v;
    m_match = 0; m_uf = 0;
  endtask

  // one clock with the given enable and direction, then compare
  task automatic cyc(input logic en, input logic up, input string req);
    clk_en = en; dir_up = up;
    m_match = 0; m_uf = 0;
    if (en && m_run) begin
      m_match = (m_cnt == m_cmp);
      if (!m_ud) m_cnt = (m_match && m_clr) ? 16'h0000 : m_cnt + 16'h0001;
      else if (up) m_cnt = m_cnt + 16'h0001;
      else if (m_cnt == 16'h0000) begin
        m_uf = 1;
        m_cnt = (!m_b && m_rl) ? m_cmp : 16'hFFFF;
      end else m_cnt = m_cnt - 16'h0001;
    end
    @(posedge clk); @(negedge clk);
    clk_en = 0;
    chk(req, "count", rd_data, m_cnt);
    chk(req, "match_o", {15'b0, match_o}, {15'b0, m_match});
    chk(req, "uf_o", {15'b0, uf_o}, {15'b0, m_uf});
  endtask

  task automatic t_reset();
    logic [15:0] v;
    for (int a = 0; a < 4; a++) begin
      rdreg(a[1:0], v);
      chk("R1", "reg after reset", v, 16'h0000);
    end
    chk("R1", "flags after reset", {14'b0, match_o, uf_o}, 16'h0000);
  endtask

  task automatic t_ctrl_bits();
    logic [15:0] v;
    wr(2'd0, 16'h00BF);
    rdreg(2'd0, v);
    chk("R2", "ctrl implemented bits", v, 16'h000C);
    wr(2'd0, 16'h0000);
    rdreg(2'd0, v);
    chk("R2", "ctrl cleared", v, 16'h0000);
  endtask

  task automatic t_bit_write();
    logic [15:0] v;
    bitw(3'd3, 1'b1);
    rdreg(2'd0, v); chk("R11", "bit 3 set", v, 16'h0008);
    bitw(3'd7, 1'b1);
    rdreg(2'd0, v); chk("R11", "bit 7 stays 0", v, 16'h0008);
    bitw(3'd3, 1'b0);
    rdreg(2'd0, v); chk("R11", "bit 3 cleared", v, 16'h0000);
    // byte write and bit write together: byte wins
    clk_en = 0; wr_en = 1; wr_addr = 2'd0; wr_data = 16'h0004;
    bit_we = 1; bit_sel = 3'd3; bit_val = 1'b1;
    @(posedge clk); @(negedge clk);
    wr_en = 0; bit_we = 0;
    m_clr = 1; m_rl = 0;
    rdreg(2'd0, v); chk("R11", "byte write priority", v, 16'h0004);
    wr(2'd0, 16'h0000);
  endtask

  task automatic t_gp_free();
    wr(2'd1, 16'h0000);
    wr(2'd2, 16'h0003);
    wr(2'd0, 16'h0048);   // run + reload (no effect in GP), no clear
    for (int i = 0; i < 6; i++) cyc(1'b1, i[0], "R4/R13/R9");
    cyc(1'b0, 1'b1, "R3 clk_en low");
    wr(2'd0, 16'h0008);   // stop
    cyc(1'b1, 1'b1, "R3 run low");
  endtask

  task automatic t_gp_clear();
    wr(2'd0, 16'h0004);
    wr(2'd2, m_cnt + 16'd3);
    wr(2'd0, 16'h0044);
    for (int i = 0; i < 4; i++) cyc(1'b1, 1'b0, "R5");
    chk("R5", "cleared to zero", rd_data, 16'h0000);
    cyc(1'b1, 1'b0, "R5 after clear");
  endtask

  task automatic t_protect();
    logic [15:0] v;
    wr(2'd0, 16'h0048);   // attempt to change reload/clear while running
    rdreg(2'd0, v); chk("R10", "protected byte write", v, 16'h0044);
    bitw(3'd2, 1'b0);
    rdreg(2'd0, v); chk("R11", "protected bit write", v, 16'h0044);
    wr(2'd1, 16'h0003);
    rdreg(2'd1, v); chk("R12", "mode frozen", v, 16'h0000);
    wr(2'd2, 16'h1234);
    rdreg(2'd2, v); chk("R12", "compare writable", v, 16'h1234);
    bitw(3'd6, 1'b0);
    rdreg(2'd0, v); chk("R10", "run cleared by bit write", v, 16'h0004);
  endtask

  task automatic t_mode_b();
    // bring count to zero in GP with clear
    wr(2'd2, m_cnt);
    wr(2'd0, 16'h0044);
    cyc(1'b1, 1'b1, "R5");
    wr(2'd0, 16'h0000);
    wr(2'd1, 16'h0003);
    wr(2'd2, 16'h0001);
    wr(2'd0, 16'h004C);   // clear and reload set, both ignored in mode B
    cyc(1'b1, 1'b1, "R6 up");
    cyc(1'b1, 1'b1, "R6/R9 match no clear");
    cyc(1'b1, 1'b0, "R6 down");
    cyc(1'b1, 1'b0, "R6 down");
    cyc(1'b1, 1'b0, "R7/R9 underflow no reload");
    chk("R7", "wrapped", rd_data, 16'hFFFF);
    cyc(1'b1, 1'b1, "R6 wrap up");
    wr(2'd0, 16'h0000);
  endtask

  task automatic t_mode_a();
    wr(2'd1, 16'h0001);
    wr(2'd2, 16'h0003);
    wr(2'd0, 16'h0048);
    cyc(1'b1, 1'b0, "R8 reload");
    chk("R8", "reloaded", rd_data, 16'h0003);
    for (int i = 0; i < 3; i++) cyc(1'b1, 1'b0, "R6");
    cyc(1'b1, 1'b0, "R8 second reload");
    wr(2'd0, 16'h0000);
    wr(2'd0, 16'h0040);   // no reload
    for (int i = 0; i < 4; i++) cyc(1'b1, 1'b0, "R7 no reload");
    wr(2'd0, 16'h0000);
  endtask

  task automatic t_coincide();
    // reach zero counting up from 0xFFFF in mode A
    wr(2'd2, 16'h0000);
    wr(2'd0, 16'h0048);
    while (m_cnt != 16'h0000) cyc(1'b1, 1'b1, "R6");
    cyc(1'b1, 1'b0, "R7/R8/R13 together");
    chk("R13", "both flags", {14'b0, match_o, uf_o}, 16'h0003);
    cyc(1'b1, 1'b0, "R7/R8/R13 repeat");
    wr(2'd0, 16'h0000);
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ctrl_bits();
    t_bit_write();
    t_gp_free();
    t_gp_clear();
    t_protect();
    t_mode_b();
    t_mode_a();
    t_coincide();
    summary();
    $finish;
  end

endmodule